// File: doc/BRIEF.md
# Radix-Adjustable Nibble ALU

This block is the arithmetic and logic stage of a 4-bit datapath. It takes two 4-bit operands, an operation code and a radix value. It returns a 4-bit result, together with the carry and zero values that the operation produces. The carry input for the carry-using operations always comes from the block's own registered C flag. The flag register is loaded from the new carry and zero values only when a write strobe is high.

The add, subtract, increment and decrement operations fold their raw outcome back into the chosen radix, which can be any value from 1 to 16. A radix of 10 gives decimal digit arithmetic and a radix of 16 gives plain binary. Multi-digit counters in any base can be built one digit at a time by chaining through the C flag.

Compare runs the subtraction for its flags only. The logic operations leave C alone. The rotates pass through the C flag.

Top module: `radix_alu`

## Requirements
- R1: Op code 0 (add) gives s = opa + opb, and op code 1 (add with carry) gives s = opa + opb + C. With radix n, the result is s mod n and carry_next is 1 exactly when s >= n. This holds for operands below n; operands at or above n give an unspecified result.
- R2: Op code 2 (subtract) gives d = opa - opb, and op code 3 (subtract with borrow) gives d = opa - opb - C. carry_next is 1 exactly when d < 0, and the result is d + n when d < 0, otherwise d. This holds for operands below n.
- R3: Op code 5 (increment) computes opa + 1 and op code 6 (decrement) computes opa - 1, both folded into radix n with the same carry and borrow rule as R1 and R2. opb is ignored for both.
- R4: The radix input carries the value n directly. The codes 0 and 17 to 31 are treated as 16, and radix 16 behaves as plain modulo-16 binary arithmetic.
- R5: Op code 4 (compare) produces carry_next and zero_next as op code 2 would, while result equals opa unchanged.
- R6: Op codes 7, 8 and 9 give bitwise AND, OR and XOR of opa and opb. For these, carry_next equals the current C flag.
- R7: Op code 10 shifts opa left and op code 11 shifts it right, both filling with 0. carry_next takes the bit shifted out: bit 3 for the left shift, bit 0 for the right shift.
- R8: Op code 12 rotates left through carry: the old C goes into bit 0 and the old bit 3 goes into carry_next. Op code 13 rotates right through carry: the old C goes into bit 3 and the old bit 0 goes into carry_next.
- R9: For op codes 0 to 13, zero_next is 1 exactly when the 4-bit outcome is zero. For compare, that outcome is the difference.
- R10: carry_flag and zero_flag load carry_next and zero_next on a rising clock edge when flag_we is 1. When flag_we is 0 they hold.
- R11: A synchronous active-high rst clears both flags on the next rising edge.
- R12: Op codes 14 and 15 return opa as result, and carry_next and zero_next equal the current flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| flag_we | input | 1 | Strobe that loads the new flag values |
| op | input | 4 | Operation code |
| opa | input | 4 | First operand |
| opb | input | 4 | Second operand |
| radix | input | 5 | Radix value, 1 to 16 (0 and over 16 act as 16) |
| result | output | 4 | Operation result |
| carry_next | output | 1 | Carry or borrow produced by the operation |
| zero_next | output | 1 | Zero indication produced by the operation |
| carry_flag | output | 1 | Registered C flag, also the carry input |
| zero_flag | output | 1 | Registered Z flag |

## Verification
The arithmetic operations are swept over every radix from 1 to 16, every in-range operand pair and both carry-flag values. This separates a wrong fold-back amount from a wrong carry threshold, and separates an ignored carry from a doubly applied one.

The logic, shift and rotate operations are swept over all operand pairs with C at both values. This shows whether the carry is kept, replaced by the shifted-out bit, or fed into the vacated bit.

Separate short sequences exercise the following:
- the out-of-range radix codes;
- the reserved op codes;
- flag loading with and without the strobe;
- the synchronous reset.

// File: rtl/radix_alu_pkg.sv
package radix_alu_pkg;
  parameter int unsigned DIGIT_W = 4;
  localparam int unsigned RADIX_W = DIGIT_W + 1;
  localparam int unsigned WIDE_W  = DIGIT_W + 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_RL   = 4'd12,
    OP_RR   = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  // Map any radix code onto 1 .. 2**DIGIT_W
  function automatic logic [RADIX_W-1:0] norm_radix(input logic [RADIX_W-1:0] code);
    logic [RADIX_W-1:0] full;
    full = RADIX_W'(1) << DIGIT_W;
    if (code == '0 || code > full) return full;
    return code;
  endfunction

  // Returns {carry, digit}
  function automatic logic [DIGIT_W:0] radix_add(input logic [DIGIT_W-1:0] a,
                                                 input logic [DIGIT_W-1:0] b,
                                                 input logic cin,
                                                 input logic [RADIX_W-1:0] n);
    logic [WIDE_W-1:0] total;
    logic [WIDE_W-1:0] folded;
    total  = WIDE_W'(a) + WIDE_W'(b) + WIDE_W'(cin);
    folded = total - WIDE_W'(n);
    if (total >= WIDE_W'(n)) return {1'b1, folded[DIGIT_W-1:0]};
    return {1'b0, total[DIGIT_W-1:0]};
  endfunction

  // Returns {borrow, digit}
  function automatic logic [DIGIT_W:0] radix_sub(input logic [DIGIT_W-1:0] a,
                                                 input logic [DIGIT_W-1:0] b,
                                                 input logic bin,
                                                 input logic [RADIX_W-1:0] n);
    logic [WIDE_W-1:0] need;
    logic [WIDE_W-1:0] wrapped;
    logic [WIDE_W-1:0] plain;
    need    = WIDE_W'(b) + WIDE_W'(bin);
    wrapped = WIDE_W'(a) + WIDE_W'(n) - need;
    plain   = WIDE_W'(a) - need;
    if (WIDE_W'(a) < need) return {1'b1, wrapped[DIGIT_W-1:0]};
    return {1'b0, plain[DIGIT_W-1:0]};
  endfunction
endpackage

// File: rtl/radix_alu_arith.sv
module radix_alu_arith
  import radix_alu_pkg::*;
(
  input  alu_op_e              op,
  input  logic [DIGIT_W-1:0]   a,
  input  logic [DIGIT_W-1:0]   b,
  input  logic                 cin,
  input  logic [RADIX_W-1:0]   n,
  output logic [DIGIT_W-1:0]   res,
  output logic                 c_out,
  output logic                 sel
);
  localparam logic [DIGIT_W-1:0] ONE = DIGIT_W'(1);

  always_comb begin
    sel = 1'b1;
    unique case (op)
      OP_ADD:  {c_out, res} = radix_add(a, b, 1'b0, n);
      OP_ADC:  {c_out, res} = radix_add(a, b, cin, n);
      OP_SUB:  {c_out, res} = radix_sub(a, b, 1'b0, n);
      OP_SBC:  {c_out, res} = radix_sub(a, b, cin, n);
      OP_CMP:  {c_out, res} = radix_sub(a, b, 1'b0, n);
      OP_INC:  {c_out, res} = radix_add(a, ONE, 1'b0, n);
      OP_DEC:  {c_out, res} = radix_sub(a, ONE, 1'b0, n);
      default: begin
        {c_out, res} = '0;
        sel = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/radix_alu_logic.sv
module radix_alu_logic
  import radix_alu_pkg::*;
(
  input  alu_op_e              op,
  input  logic [DIGIT_W-1:0]   a,
  input  logic [DIGIT_W-1:0]   b,
  input  logic                 cin,
  output logic [DIGIT_W-1:0]   res,
  output logic                 c_out,
  output logic                 sel
);
  localparam int unsigned MSB = DIGIT_W - 1;

  always_comb begin
    sel   = 1'b1;
    c_out = cin;
    res   = a;
    unique case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SLL: begin res = {a[MSB-1:0], 1'b0}; c_out = a[MSB]; end
      OP_SRL: begin res = {1'b0, a[MSB:1]};   c_out = a[0];   end
      OP_RL:  begin res = {a[MSB-1:0], cin};  c_out = a[MSB]; end
      OP_RR:  begin res = {cin, a[MSB:1]};    c_out = a[0];   end
      default: sel = 1'b0;
    endcase
  end
endmodule

// File: rtl/radix_alu_flags.sv
module radix_alu_flags (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic c_in,
  input  logic z_in,
  output logic c_q,
  output logic z_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (we) begin
      c_q <= c_in;
      z_q <= z_in;
    end
  end
endmodule

// File: rtl/radix_alu.sv
module radix_alu
  import radix_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               flag_we,
  input  logic [3:0]         op,
  input  logic [DIGIT_W-1:0] opa,
  input  logic [DIGIT_W-1:0] opb,
  input  logic [RADIX_W-1:0] radix,
  output logic [DIGIT_W-1:0] result,
  output logic               carry_next,
  output logic               zero_next,
  output logic               carry_flag,
  output logic               zero_flag
);
  alu_op_e            op_e;
  logic [RADIX_W-1:0] eff_radix;
  logic [DIGIT_W-1:0] arith_res, logic_res;
  logic               arith_c, logic_c;
  logic               arith_sel, logic_sel;

  assign op_e      = alu_op_e'(op);
  assign eff_radix = norm_radix(radix);

  radix_alu_arith u_arith (
    .op(op_e), .a(opa), .b(opb), .cin(carry_flag), .n(eff_radix),
    .res(arith_res), .c_out(arith_c), .sel(arith_sel)
  );

  radix_alu_logic u_logic (
    .op(op_e), .a(opa), .b(opb), .cin(carry_flag),
    .res(logic_res), .c_out(logic_c), .sel(logic_sel)
  );

  always_comb begin
    if (arith_sel) begin
      result     = (op_e == OP_CMP) ? opa : arith_res;
      carry_next = arith_c;
      zero_next  = (arith_res == '0);
    end else if (logic_sel) begin
      result     = logic_res;
      carry_next = logic_c;
      zero_next  = (logic_res == '0);
    end else begin
      result     = opa;
      carry_next = carry_flag;
      zero_next  = zero_flag;
    end
  end

  radix_alu_flags u_flags (
    .clk(clk), .rst(rst), .we(flag_we),
    .c_in(carry_next), .z_in(zero_next),
    .c_q(carry_flag), .z_q(zero_flag)
  );
endmodule

// File: rtl/radix_alu_chk.sv
module radix_alu_chk
  import radix_alu_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               flag_we,
  input logic [3:0]         op,
  input logic [DIGIT_W-1:0] opa,
  input logic [DIGIT_W-1:0] opb,
  input logic [RADIX_W-1:0] eff_radix,
  input logic               arith_sel,
  input logic [DIGIT_W-1:0] result,
  input logic               carry_next,
  input logic               zero_next,
  input logic               carry_flag,
  input logic               zero_flag
);
  AST_RADIX_BOUND: assert property (@(posedge clk) disable iff (rst)
    (arith_sel && op != OP_CMP && RADIX_W'(opa) < eff_radix && RADIX_W'(opb) < eff_radix)
      |-> RADIX_W'(result) < eff_radix); // R1

  AST_CMP_KEEPS_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |-> result == opa); // R5

  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_AND || op == OP_OR || op == OP_XOR) |-> carry_next == carry_flag); // R6

  AST_ROTL_THROUGH_C: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RL) |-> (carry_next == opa[DIGIT_W-1] && result[0] == carry_flag)); // R8

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (op != OP_CMP && op < OP_RSV0) |-> zero_next == (result == '0)); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> ($stable(carry_flag) && $stable(zero_flag))); // R10

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (carry_flag == $past(carry_next) && zero_flag == $past(zero_next))); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!carry_flag && !zero_flag)); // R11

  AST_RESERVED_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op >= OP_RSV0) |-> (carry_next == carry_flag && zero_next == zero_flag)); // R12
endmodule

bind radix_alu radix_alu_chk u_chk (.*);

// File: tb/radix_alu_test.sv
`timescale 1ns/100ps
module radix_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flag_we = 1'b0;
  logic [3:0] op = 4'd0;
  logic [3:0] opa = 4'd0;
  logic [3:0] opb = 4'd0;
  logic [4:0] radix = 5'd16;
  logic [3:0] result;
  logic       carry_next, zero_next, carry_flag, zero_flag;

  int tests = 0;
  int fails = 0;
  int cur_c = 0;
  int cur_z = 0;

  always #2.5 clk = ~clk;

  radix_alu uut (
    .clk(clk), .rst(rst), .flag_we(flag_we), .op(op), .opa(opa), .opb(opb),
    .radix(radix), .result(result), .carry_next(carry_next), .zero_next(zero_next),
    .carry_flag(carry_flag), .zero_flag(zero_flag)
  );

  function automatic string req_of(input int code);
    case (code)
      0, 1:          return "R1";
      2, 3:          return "R2";
      4:             return "R5";
      5, 6:          return "R3";
      7, 8, 9:       return "R6";
      10, 11:        return "R7";
      12, 13:        return "R8";
      default:       return "R12";
    endcase
  endfunction

  // Expected outcome from the requirement arithmetic
  task automatic model(input int code, input int a, input int b, input int rcode,
                       input int cin, input int zin,
                       output int r, output int c, output int z);
    int n, t;
    n = (rcode == 0 || rcode > 16) ? 16 : rcode;
    r = a; c = cin; z = zin;
    case (code)
      0, 1, 5: begin
        t = (code == 5) ? a + 1 : a + b + ((code == 1) ? cin : 0);
        r = t % n; c = (t / n) != 0 ? 1 : 0; z = (r == 0);
      end
      2, 3, 4, 6: begin
        t = (code == 6) ? a - 1 : a - b - ((code == 3) ? cin : 0);
        c = (t < 0) ? 1 : 0;
        r = (t + n) % n; z = (r == 0);
        if (code == 4) r = a;
      end
      7:  begin r = a & b; z = (r == 0); end
      8:  begin r = a | b; z = (r == 0); end
      9:  begin r = a ^ b; z = (r == 0); end
      10: begin r = (a * 2) % 16; c = a / 8; z = (r == 0); end
      11: begin r = a / 2; c = a % 2; z = (r == 0); end
      12: begin r = (a * 2) % 16 + cin; c = a / 8; z = (r == 0); end
      13: begin r = a / 2 + cin * 8; c = a % 2; z = (r == 0); end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input int code, input int a, input int b, input int rcode);
    int r, c, z;
    op = 4'(code); opa = 4'(a); opb = 4'(b); radix = 5'(rcode);
    #1;
    model(code, a, b, rcode, cur_c, cur_z, r, c, z);
    if (code >= 14 || !(result == 4'(r) && carry_next == c[0] && zero_next == z[0])) begin
      check(req_of(code), "result", int'(result), r);
      check(req_of(code), "carry", int'(carry_next), c);
      check(code >= 14 ? "R12" : "R9", "zero", int'(zero_next), z);
    end else begin
      tests++;
    end
  endtask

  // Load C = v and Z = v through an add with the strobe (R10)
  task automatic set_flags(input int v);
    @(negedge clk);
    op = 4'd0; radix = 5'd16; opa = v ? 4'd8 : 4'd1; opb = v ? 4'd8 : 4'd0;
    flag_we = 1'b1;
    @(negedge clk);
    flag_we = 1'b0;
    cur_c = v; cur_z = v;
    check("R10", "carry_flag load", int'(carry_flag), v);
    check("R10", "zero_flag load", int'(zero_flag), v);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R11", "carry_flag after reset", int'(carry_flag), 0);
    check("R11", "zero_flag after reset", int'(zero_flag), 0);

    // R1 R2 R3 R5 R9: arithmetic over every radix and in-range operand pair
    for (int cin = 0; cin < 2; cin++) begin
      set_flags(cin);
      for (int n = 1; n <= 16; n++)
        for (int a = 0; a < n; a++)
          for (int b = 0; b < n; b++)
            for (int code = 0; code <= 6; code++)
              apply(code, a, b, n);
    end

    // R6 R7 R8: logic, shifts and rotates over all operand pairs
    for (int cin = 0; cin < 2; cin++) begin
      set_flags(cin);
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int code = 7; code <= 13; code++)
            apply(code, a, b, 16);
    end

    // R4: radix codes 0 and above 16 act as 16
    set_flags(1);
    apply(0, 9, 7, 0);
    apply(1, 15, 15, 0);
    apply(3, 2, 9, 20);
    apply(6, 0, 0, 31);
    apply(5, 15, 0, 17);

    // R12: reserved codes with both flag states
    for (int v = 0; v < 2; v++) begin
      set_flags(v);
      apply(14, 11, 3, 10);
      apply(15, 0, 5, 16);
    end

    // R10: no strobe means no flag change
    set_flags(0);
    @(negedge clk);
    op = 4'd0; opa = 4'd8; opb = 4'd8; radix = 5'd16; flag_we = 1'b0;
    @(negedge clk);
    check("R10", "carry_flag hold", int'(carry_flag), 0);
    check("R10", "zero_flag hold", int'(zero_flag), 0);

    // R11: synchronous reset clears set flags
    set_flags(1);
    rst = 1'b1;
    #1;
    check("R11", "carry_flag before edge", int'(carry_flag), 1);
    @(negedge clk);
    rst = 1'b0;
    check("R11", "carry_flag cleared", int'(carry_flag), 0);
    check("R11", "zero_flag cleared", int'(zero_flag), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule